// File: doc/BRIEF.md
# Switch Partition State Controller

This block keeps the software-visible operating state of a single switch partition and turns it into the control signals the rest of the partition consumes. A management write port, shared by internal masters and an external management bus, requests a new state. The controller accepts only the permitted moves. It rejects every other request, leaves the state as it was and raises a sticky error flag.

From the held state the block drives a partition-wide reset, a per-port force-disable mask and a one-clock pulse that tells the register file to load its initial values. It also reads each port's configured mode and produces an effective mode for that port. When the partition is disabled, the effective mode is replaced by the disabled mode code. In the other states the configured mode passes through unchanged.

Top module: `psc_partition_ctl`

## Requirements
- R1: After the synchronous device reset the state is disabled (code 00), the error flag is 0 and the initialize pulse is 0.
- R2: The state output uses the codes 00 = disabled, 01 = fundamental reset and 10 = active. Code 11 is reserved and never held.
- R3: An accepted write changes the state on the clock edge that samples it. The accepted moves are disabled to fundamental reset, fundamental reset to active, and any state to disabled.
- R4: A write requesting disabled to active, active to fundamental reset, or code 11 leaves the state unchanged and sets the error flag.
- R5: The error flag stays set through later legal writes and is cleared only by the device reset.
- R6: The partition reset output is high exactly while the state is fundamental reset.
- R7: While the state is disabled, every port's force-disable bit is 1 and every port's effective mode is the disabled code 0, whatever its configured mode.
- R8: While the state is not disabled, every force-disable bit is 0 and each port's effective mode equals its configured mode.
- R9: The initialize pulse is high for exactly one clock, in the cycle the state first becomes fundamental reset. A rewrite of fundamental reset while already in it produces no pulse.
- R10: A write of the current state code is accepted as no change and does not set the error flag. A cycle with the write enable low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high device reset |
| wr_en | input | 1 | Write strobe for the state field |
| wr_state | input | 2 | Requested state code |
| port_mode_cfg | input | NUM_PORTS*MODE_W | Configured mode of each port, port 0 in the low bits |
| state_o | output | 2 | Current partition state code |
| part_reset | output | 1 | Partition fundamental reset |
| port_force_dis | output | NUM_PORTS | Per-port force-disable |
| reg_init_pulse | output | 1 | One-clock register-initialize strobe |
| trans_err | output | 1 | Sticky rejected-transition flag |
| port_mode_eff | output | NUM_PORTS*MODE_W | Effective mode of each port |

## Verification
The state machine is driven through the whole legal path: disabled, then fundamental reset, then active, then back to disabled. This path separates a correct transition table from one that blocks a permitted move. The three forbidden requests (skipping fundamental reset, falling back from active into fundamental reset, and the reserved code) each target a different row of the table, and the state is checked unchanged after each one. A same-value rewrite of fundamental reset separates a pulse fired on real entry from one fired on every write. Non-zero and changing port modes are used in the disabled and the active states to show that the override masks the configured modes in one case and passes them through in the other.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [1:0] {
        PS_DISABLED = 2'b00,
        PS_FRESET   = 2'b01,
        PS_ACTIVE   = 2'b10
    } part_state_e;

    localparam logic [1:0] PS_RESERVED = 2'b11;

    typedef struct packed {
        logic accept;
        logic reject;
        logic enter_reset;
    } wr_decision_t;

    function automatic logic move_allowed(input logic [1:0] cur, input logic [1:0] req);
        logic ok;
        ok = 1'b0;
        if (req == PS_RESERVED)       ok = 1'b0;
        else if (req == cur)          ok = 1'b1;
        else if (req == PS_DISABLED)  ok = 1'b1;
        else if (cur == PS_DISABLED && req == PS_FRESET) ok = 1'b1;
        else if (cur == PS_FRESET   && req == PS_ACTIVE) ok = 1'b1;
        return ok;
    endfunction

    function automatic wr_decision_t decide(input logic en, input logic [1:0] cur,
                                            input logic [1:0] req);
        wr_decision_t d;
        d.accept      = en &  move_allowed(cur, req);
        d.reject      = en & ~move_allowed(cur, req);
        d.enter_reset = d.accept & (req == PS_FRESET) & (cur != PS_FRESET);
        return d;
    endfunction

endpackage

// File: rtl/psc_state_fsm.sv
module psc_state_fsm
    import psc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_state,
    output part_state_e state,
    output logic        init_pulse,
    output logic        err_sticky
);
    wr_decision_t dec;

    always_comb begin
        dec = decide(wr_en, state, wr_state);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PS_DISABLED;
            init_pulse <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            if (dec.accept) state <= part_state_e'(wr_state);
            init_pulse <= dec.enter_reset;
            if (dec.reject) err_sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/psc_port_mask.sv
module psc_port_mask #(
    parameter int NUM_PORTS = 4,
    parameter int MODE_W    = 3
) (
    input  logic                          force_dis,
    input  logic [NUM_PORTS*MODE_W-1:0]   mode_cfg,
    output logic [NUM_PORTS*MODE_W-1:0]   mode_eff,
    output logic [NUM_PORTS-1:0]          dis_vec
);
    localparam logic [MODE_W-1:0] MODE_OFF = '0;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign dis_vec[p] = force_dis;
        assign mode_eff[p*MODE_W +: MODE_W] =
            force_dis ? MODE_OFF : mode_cfg[p*MODE_W +: MODE_W];
    end
endmodule

// File: rtl/psc_partition_ctl.sv
module psc_partition_ctl
    import psc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int MODE_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_state,
    input  logic [NUM_PORTS*MODE_W-1:0] port_mode_cfg,
    output logic [1:0]                  state_o,
    output logic                        part_reset,
    output logic [NUM_PORTS-1:0]        port_force_dis,
    output logic                        reg_init_pulse,
    output logic                        trans_err,
    output logic [NUM_PORTS*MODE_W-1:0] port_mode_eff
);
    part_state_e cur_state;

    psc_state_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_state   (wr_state),
        .state      (cur_state),
        .init_pulse (reg_init_pulse),
        .err_sticky (trans_err)
    );

    psc_port_mask #(.NUM_PORTS(NUM_PORTS), .MODE_W(MODE_W)) u_mask (
        .force_dis (cur_state == PS_DISABLED),
        .mode_cfg  (port_mode_cfg),
        .mode_eff  (port_mode_eff),
        .dis_vec   (port_force_dis)
    );

    assign state_o    = cur_state;
    assign part_reset = (cur_state == PS_FRESET);
endmodule

// File: rtl/psc_partition_chk.sv
module psc_partition_chk #(
    parameter int NUM_PORTS = 4,
    parameter int MODE_W    = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic [1:0]                  wr_state,
    input logic [NUM_PORTS*MODE_W-1:0] port_mode_cfg,
    input logic [1:0]                  state_o,
    input logic                        part_reset,
    input logic [NUM_PORTS-1:0]        port_force_dis,
    input logic                        reg_init_pulse,
    input logic                        trans_err,
    input logic [NUM_PORTS*MODE_W-1:0] port_mode_eff
);
    logic bad_req;
    assign bad_req = wr_en && (wr_state == 2'b11 ||
                               (state_o == 2'b00 && wr_state == 2'b10) ||
                               (state_o == 2'b10 && wr_state == 2'b01));

    // R2
    no_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'b11);

    // R4
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bad_req |=> ($stable(state_o) && trans_err));

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        trans_err |=> trans_err);

    // R9
    init_entry_chk: assert property (@(posedge clk) disable iff (rst)
        reg_init_pulse |-> (part_reset && $past(state_o) != 2'b01));

    // R9
    init_single_chk: assert property (@(posedge clk) disable iff (rst)
        reg_init_pulse |=> !reg_init_pulse);

    // R7
    dis_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00) |-> (port_mode_eff == '0 && &port_force_dis));

    // R8
    pass_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'b00) |-> (port_mode_eff == port_mode_cfg && port_force_dis == '0));

    // R3
    active_path_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b10 && $past(state_o) != 2'b10) |-> $past(state_o) == 2'b01);
endmodule

bind psc_partition_ctl psc_partition_chk #(.NUM_PORTS(NUM_PORTS), .MODE_W(MODE_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_state       (wr_state),
    .port_mode_cfg  (port_mode_cfg),
    .state_o        (state_o),
    .part_reset     (part_reset),
    .port_force_dis (port_force_dis),
    .reg_init_pulse (reg_init_pulse),
    .trans_err      (trans_err),
    .port_mode_eff  (port_mode_eff)
);

// File: tb/tb_psc_partition_ctl.sv
module tb_psc_partition_ctl;
    localparam int NP = 4;
    localparam int MW = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [1:0]        wr_state;
    logic [NP*MW-1:0]  cfg;
    logic [1:0]        state_o;
    logic              part_reset;
    logic [NP-1:0]     force_dis;
    logic              init_pulse;
    logic              terr;
    logic [NP*MW-1:0]  eff;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    psc_partition_ctl #(.NUM_PORTS(NP), .MODE_W(MW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_state(wr_state),
        .port_mode_cfg(cfg), .state_o(state_o), .part_reset(part_reset),
        .port_force_dis(force_dis), .reg_init_pulse(init_pulse),
        .trans_err(terr), .port_mode_eff(eff)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic dev_reset();
        @(negedge clk); rst = 1'b1; wr_en = 1'b0; wr_state = 2'b00;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    // one accepted or rejected write; returns sampled at the following negedge
    task automatic do_write(input logic [1:0] code);
        @(negedge clk); wr_en = 1'b1; wr_state = code;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic t_reset_state();
        cfg = {3'd1, 3'd7, 3'd2, 3'd5};
        dev_reset();
        check("R1 state", state_o, 2'b00);
        check("R1 err", terr, 0);
        check("R1 pulse", init_pulse, 0);
        check("R6 no reset in disabled", part_reset, 0);
    endtask

    task automatic t_disabled_mask();
        check("R7 force_dis", force_dis, 4'hF);
        check("R7 eff mode zero", eff, 0);
        cfg = {3'd6, 3'd3, 3'd4, 3'd7};
        @(negedge clk);
        check("R7 eff zero after cfg change", eff, 0);
        @(negedge clk); wr_en = 1'b0; wr_state = 2'b01;
        @(negedge clk);
        check("R10 no write when enable low", state_o, 2'b00);
    endtask

    task automatic t_enter_reset();
        do_write(2'b01);
        check("R3 dis->freset", state_o, 2'b01);
        check("R9 pulse on entry", init_pulse, 1);
        check("R6 reset high", part_reset, 1);
        check("R8 eff passes in freset", eff, cfg);
        check("R8 force_dis low", force_dis, 0);
        @(negedge clk);
        check("R9 pulse one cycle", init_pulse, 0);
        do_write(2'b01);
        check("R9 no pulse on rewrite", init_pulse, 0);
        check("R10 rewrite no err", terr, 0);
        check("R10 rewrite keeps state", state_o, 2'b01);
    endtask

    task automatic t_activate();
        do_write(2'b10);
        check("R3 freset->active", state_o, 2'b10);
        check("R6 reset low in active", part_reset, 0);
        check("R9 no pulse into active", init_pulse, 0);
        cfg = {3'd2, 3'd0, 3'd5, 3'd3};
        @(negedge clk);
        check("R8 eff follows cfg", eff, cfg);
        check("R4 no err yet", terr, 0);
    endtask

    task automatic t_illegal_from_active();
        do_write(2'b01);
        check("R4 active->freset rejected", state_o, 2'b10);
        check("R4 err set", terr, 1);
        check("R9 no pulse on rejected", init_pulse, 0);
        do_write(2'b11);
        check("R2 reserved rejected", state_o, 2'b10);
    endtask

    task automatic t_sticky_and_disable();
        do_write(2'b00);
        check("R3 active->dis", state_o, 2'b00);
        check("R5 err sticky", terr, 1);
        check("R7 mask again", eff, 0);
        dev_reset();
        check("R5 err cleared by reset", terr, 0);
    endtask

    task automatic t_skip_reset();
        do_write(2'b10);
        check("R4 dis->active rejected", state_o, 2'b00);
        check("R4 err on skip", terr, 1);
        dev_reset();
        do_write(2'b01);
        do_write(2'b00);
        check("R3 freset->dis", state_o, 2'b00);
        check("R6 reset released", part_reset, 0);
        do_write(2'b01);
        check("R9 pulse on re-entry", init_pulse, 1);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_state = 2'b00; cfg = '0;
        t_reset_state();
        t_disabled_mask();
        t_enter_reset();
        t_activate();
        t_illegal_from_active();
        t_sticky_and_disable();
        t_skip_reset();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule